// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder

This block watches the control pins of a two-bank SDRAM device and turns the pin state seen at each rising clock edge into exactly one decoded command. The command is presented one clock later as a one-hot vector, together with the bank, the low address bits and the auto-precharge bit captured at the same edge. A memory controller model, a protocol monitor or a device model can place it beside the command bus to learn what the device is being asked to do.

Beyond plain decoding, the block keeps the state that gives a command its meaning. It tracks which banks hold an open row, whether the clock is suspended, and whether the device is in power-down or self-refresh. It also models the read and write data windows: burst length, CAS latency, burst terminate, and the different delays with which the data-mask pin acts on reads and on writes. Illegal sequences raise a one-cycle violation pulse or a sticky protocol error.

Top module: `sdr_cmd_classifier`

## Requirements
- R1: Every command is reported one clock after the edge where its pins were sampled, as exactly one bit of `cmd_onehot` with these bit positions: 0 suspended, 1 deselect, 2 no-op, 3 mode-register set, 4 auto refresh, 5 self-refresh entry, 6 precharge one bank, 7 precharge all banks, 8 activate, 9 write, 10 write with auto-precharge, 11 read, 12 read with auto-precharge, 13 burst terminate. After reset `cmd_onehot` shows no-op, all banks are closed and every flag and data window output is low.
- R2: With `cke` high at the previous edge and `cs_n` high, the command is deselect whatever the other pins are, and bank state does not change.
- R3: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} selects the command: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst terminate, 111 no-op.
- R4: A refresh with `cke` high at the previous and the current edge is auto refresh. A refresh with `cke` low at the current edge is self-refresh entry. `self_refresh` then stays high until an edge samples `cke` high.
- R5: `bank_sel` 0 addresses bank A (`bank_open[0]`) and 1 addresses bank B (`bank_open[1]`). Precharge with `ap_bit` low closes only the selected bank. With `ap_bit` high it closes both banks.
- R6: Activate opens the selected bank. Read or write with `ap_bit` high is reported as the auto-precharge variant and closes the addressed bank at that edge. `cmd_bank`, `cmd_ap` and `cmd_addr` show the pin values of the reported command.
- R7: When `cke` was low at the previous edge, the command pins are ignored. The command is reported as suspended, bank state holds, and burst progress freezes, so the burst gets longer by one clock per suspended edge.
- R8: A write sampled at edge k gives `wr_beat` high after edges k to k+BURST_LEN-1. `wr_mask` follows `dqm` sampled at the same edge as the beat, with zero latency.
- R9: A read sampled at edge k gives `rd_beat` high after edges k+CAS_LAT to k+CAS_LAT+BURST_LEN-1. `rd_oe` is low on a beat when `dqm` was high two edges earlier.
- R10: A burst terminate stops a write burst at its own edge. It stops a read burst from CAS_LAT edges later.
- R11: `cke` falling with a no-op or deselect while no burst is active enters power-down. `power_down` stays high until an edge samples `cke` high. `viol` pulses for one cycle if any bank is open at entry.
- R12: When power-down lasts REF_LIMIT clocks past entry, `viol` pulses once, after edge entry+REF_LIMIT.
- R13: `proto_err` goes high on an activate to an open bank, or a read or write to a closed bank. It stays high until synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask / output disable |
| bank_sel | input | $clog2(BANKS) | Bank select |
| ap_bit | input | 1 | Auto-precharge / all-banks address bit |
| addr_lo | input | ADDR_W | Low address bits |
| cmd_onehot | output | 14 | Decoded command, one-hot |
| cmd_bank | output | $clog2(BANKS) | Bank of reported command |
| cmd_ap | output | 1 | Auto-precharge bit of reported command |
| cmd_addr | output | ADDR_W | Address of reported command |
| bank_open | output | BANKS | Open-bank map |
| power_down | output | 1 | Device in power-down |
| self_refresh | output | 1 | Device in self-refresh |
| rd_beat | output | 1 | Read data beat slot |
| rd_oe | output | 1 | Read data output enabled |
| wr_beat | output | 1 | Write data beat slot |
| wr_mask | output | 1 | Current write beat masked |
| viol | output | 1 | One-cycle power-down violation pulse |
| proto_err | output | 1 | Sticky bank-protocol error |

## Verification
Some invariants are checked by assertions on every cycle. The command vector is always one-hot. An activate leaves its bank open and a precharge-all leaves none open. Auto-precharge commands leave their bank closed. A suspended cycle never changes bank state. Masks and output enables only occur inside a beat. Power-down and self-refresh never overlap, and the violation flag is never longer than one cycle. Other behaviours only the directed scenarios can show: exact beat timing against CAS latency, the two-edge delay of the read mask against the zero-latency write mask, where burst terminate cuts each burst, how far a suspended clock stretches a burst, and when the refresh-period violation fires.

// File: rtl/sdr_cmd_pkg.sv
// Shared command encoding for the SDRAM command decoder.
// The enum value is also the bit position of the command in the one-hot output.
package sdr_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_SUSP    = 4'd0,
        CMD_DESEL   = 4'd1,
        CMD_NOP     = 4'd2,
        CMD_MRS     = 4'd3,
        CMD_AREF    = 4'd4,
        CMD_SREF    = 4'd5,
        CMD_PRE_ONE = 4'd6,
        CMD_PRE_ALL = 4'd7,
        CMD_ACT     = 4'd8,
        CMD_WR      = 4'd9,
        CMD_WRA     = 4'd10,
        CMD_RD      = 4'd11,
        CMD_RDA     = 4'd12,
        CMD_BST     = 4'd13
    } cmd_e;

    localparam int CMD_N = 14;

endpackage

// File: rtl/sdr_cmd_decode.sv
// Pure combinational classifier of one sampled pin set.
// Assumes cke_prev is the clock enable registered at the previous edge.
module sdr_cmd_decode
    import sdr_cmd_pkg::*;
(
    input  logic cke_prev,
    input  logic cke_now,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap,
    output cmd_e cmd
);

    // Map pin state to exactly one command code.
    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev) begin
            cmd = CMD_SUSP;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = cke_now ? CMD_AREF : CMD_SREF;
                3'b010:  cmd = ap ? CMD_PRE_ALL : CMD_PRE_ONE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = ap ? CMD_WRA : CMD_WR;
                3'b101:  cmd = ap ? CMD_RDA : CMD_RD;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdr_bank_tracker.sv
// Per-bank open-row tracking and sticky bank-protocol error.
// Assumes cmd is already CMD_SUSP on suspended cycles, so state holds then.
module sdr_bank_tracker
    import sdr_cmd_pkg::*;
#(
    parameter int BANKS = 2
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  cmd_e                     cmd,
    input  logic [$clog2(BANKS)-1:0] bank,
    output logic [BANKS-1:0]         bank_open,
    output logic                     proto_err
);

    localparam int BW = $clog2(BANKS);

    logic is_rw;
    assign is_rw = (cmd == CMD_WR) || (cmd == CMD_WRA) || (cmd == CMD_RD) || (cmd == CMD_RDA);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank == BW'(b));

        // Open on activate, close on precharge or auto-precharge access.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b] <= 1'b0;
            end else begin
                case (cmd)
                    CMD_ACT:                   if (hit) bank_open[b] <= 1'b1;
                    CMD_PRE_ONE:               if (hit) bank_open[b] <= 1'b0;
                    CMD_PRE_ALL:               bank_open[b] <= 1'b0;
                    CMD_WRA, CMD_RDA:          if (hit) bank_open[b] <= 1'b0;
                    default:                   bank_open[b] <= bank_open[b];
                endcase
            end
        end
    end

    // Latch any activate-on-open or access-to-closed until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
        end else if (((cmd == CMD_ACT) && bank_open[bank]) || (is_rw && !bank_open[bank])) begin
            proto_err <= 1'b1;
        end
    end

endmodule

// File: rtl/sdr_power_ctl.sv
// Power-down and self-refresh state with the power-down violation pulse.
// Assumes REF_LIMIT >= 2 so entry and expiry pulses never touch.
module sdr_power_ctl
    import sdr_cmd_pkg::*;
#(
    parameter int REF_LIMIT = 64
)(
    input  logic clk,
    input  logic rst_n,
    input  logic cke_prev,
    input  logic cke_now,
    input  cmd_e cmd,
    input  logic any_open,
    input  logic busy,
    output logic power_down,
    output logic self_refresh,
    output logic viol
);

    localparam int CW = $clog2(REF_LIMIT + 1);

    logic [CW-1:0] pd_cnt;
    logic          pd_enter;

    assign pd_enter = cke_prev && !cke_now && !busy &&
                      ((cmd == CMD_NOP) || (cmd == CMD_DESEL));

    // Power-down entry, residency count and violation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power_down <= 1'b0;
            pd_cnt     <= '0;
            viol       <= 1'b0;
        end else begin
            viol <= 1'b0;
            if (pd_enter) begin
                power_down <= 1'b1;
                pd_cnt     <= '0;
                viol       <= any_open;
            end else if (power_down) begin
                if (cke_now) begin
                    power_down <= 1'b0;
                end else if (pd_cnt != CW'(REF_LIMIT)) begin
                    pd_cnt <= pd_cnt + CW'(1);
                    if (pd_cnt == CW'(REF_LIMIT - 1)) viol <= 1'b1;
                end
            end
        end
    end

    // Self-refresh held from its entry command until cke is sampled high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            self_refresh <= 1'b0;
        end else if (cmd == CMD_SREF) begin
            self_refresh <= 1'b1;
        end else if (self_refresh && cke_now) begin
            self_refresh <= 1'b0;
        end
    end

endmodule

// File: rtl/sdr_data_window.sv
// Read and write burst windows with data-mask timing and burst terminate.
// Assumes CAS_LAT >= 2; burst progress freezes while adv is low.
module sdr_data_window
    import sdr_cmd_pkg::*;
#(
    parameter int CAS_LAT   = 2,
    parameter int BURST_LEN = 4
)(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  cmd_e cmd,
    input  logic dqm,
    output logic rd_beat,
    output logic rd_oe,
    output logic wr_beat,
    output logic wr_mask,
    output logic busy
);

    localparam int CW = $clog2(BURST_LEN + 1);

    logic [CAS_LAT-1:0] rd_pipe, bst_pipe;
    logic [CW-1:0]      rd_cnt, rd_cnt_n, wr_cnt, wr_cnt_n;
    logic               dqm_p1, dqm_p2;
    logic               rd_cmd, wr_cmd, bst_cmd, rd_now, wr_now;

    assign rd_cmd  = (cmd == CMD_RD) || (cmd == CMD_RDA);
    assign wr_cmd  = (cmd == CMD_WR) || (cmd == CMD_WRA);
    assign bst_cmd = (cmd == CMD_BST);
    assign busy    = (rd_cnt != '0) || (wr_cnt != '0) || (|rd_pipe);

    // Read beat: start after CAS latency, cut by a delayed terminate.
    always_comb begin
        rd_now   = 1'b0;
        rd_cnt_n = rd_cnt;
        if (rd_pipe[CAS_LAT-1]) begin
            rd_now   = 1'b1;
            rd_cnt_n = CW'(BURST_LEN - 1);
        end else if (bst_pipe[CAS_LAT-1]) begin
            rd_cnt_n = '0;
        end else if (rd_cnt != '0) begin
            rd_now   = 1'b1;
            rd_cnt_n = rd_cnt - CW'(1);
        end
    end

    // Write beat: start at the command edge, cut at once by terminate.
    always_comb begin
        wr_now   = 1'b0;
        wr_cnt_n = wr_cnt;
        if (wr_cmd) begin
            wr_now   = 1'b1;
            wr_cnt_n = CW'(BURST_LEN - 1);
        end else if (bst_cmd) begin
            wr_cnt_n = '0;
        end else if (wr_cnt != '0) begin
            wr_now   = 1'b1;
            wr_cnt_n = wr_cnt - CW'(1);
        end
    end

    // Data-mask history runs on every edge regardless of clock suspend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqm_p1 <= 1'b0;
            dqm_p2 <= 1'b0;
        end else begin
            dqm_p1 <= dqm;
            dqm_p2 <= dqm_p1;
        end
    end

    // Burst state advances only on non-suspended edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pipe  <= '0;
            bst_pipe <= '0;
            rd_cnt   <= '0;
            wr_cnt   <= '0;
            rd_beat  <= 1'b0;
            rd_oe    <= 1'b0;
            wr_beat  <= 1'b0;
            wr_mask  <= 1'b0;
        end else if (adv) begin
            rd_pipe  <= {rd_pipe[CAS_LAT-2:0], rd_cmd};
            bst_pipe <= {bst_pipe[CAS_LAT-2:0], bst_cmd};
            rd_cnt   <= rd_cnt_n;
            wr_cnt   <= wr_cnt_n;
            rd_beat  <= rd_now;
            rd_oe    <= rd_now && !dqm_p2;
            wr_beat  <= wr_now;
            wr_mask  <= wr_now && dqm;
        end
    end

endmodule

// File: rtl/sdr_cmd_classifier.sv
// Top of the two-bank SDRAM command decoder.
// Samples pins each rising edge and reports the command one clock later,
// along with bank, power and data-window state. Assumes BANKS is a power of 2.
module sdr_cmd_classifier
    import sdr_cmd_pkg::*;
#(
    parameter int BANKS     = 2,
    parameter int ADDR_W    = 11,
    parameter int CAS_LAT   = 2,
    parameter int BURST_LEN = 4,
    parameter int REF_LIMIT = 64
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic                     dqm,
    input  logic [$clog2(BANKS)-1:0] bank_sel,
    input  logic                     ap_bit,
    input  logic [ADDR_W-1:0]        addr_lo,
    output logic [CMD_N-1:0]         cmd_onehot,
    output logic [$clog2(BANKS)-1:0] cmd_bank,
    output logic                     cmd_ap,
    output logic [ADDR_W-1:0]        cmd_addr,
    output logic [BANKS-1:0]         bank_open,
    output logic                     power_down,
    output logic                     self_refresh,
    output logic                     rd_beat,
    output logic                     rd_oe,
    output logic                     wr_beat,
    output logic                     wr_mask,
    output logic                     viol,
    output logic                     proto_err
);

    logic cke_q;
    cmd_e cmd_now;
    logic busy;

    // Previous-edge clock enable; reset assumes the clock was running.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    sdr_cmd_decode u_dec (
        .cke_prev (cke_q),
        .cke_now  (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ap       (ap_bit),
        .cmd      (cmd_now)
    );

    // Register the decoded command and its captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_onehot <= CMD_N'(1) << CMD_NOP;
            cmd_bank   <= '0;
            cmd_ap     <= 1'b0;
            cmd_addr   <= '0;
        end else begin
            cmd_onehot <= CMD_N'(1) << cmd_now;
            cmd_bank   <= bank_sel;
            cmd_ap     <= ap_bit;
            cmd_addr   <= addr_lo;
        end
    end

    sdr_bank_tracker #(.BANKS(BANKS)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd_now),
        .bank      (bank_sel),
        .bank_open (bank_open),
        .proto_err (proto_err)
    );

    sdr_power_ctl #(.REF_LIMIT(REF_LIMIT)) u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke_prev     (cke_q),
        .cke_now      (cke),
        .cmd          (cmd_now),
        .any_open     (|bank_open),
        .busy         (busy),
        .power_down   (power_down),
        .self_refresh (self_refresh),
        .viol         (viol)
    );

    sdr_data_window #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (cke_q),
        .cmd     (cmd_now),
        .dqm     (dqm),
        .rd_beat (rd_beat),
        .rd_oe   (rd_oe),
        .wr_beat (wr_beat),
        .wr_mask (wr_mask),
        .busy    (busy)
    );

endmodule

// File: rtl/sdr_cmd_classifier_chk.sv
// Property checker for the SDRAM command decoder, bound to its top.
// Observes only top-level ports; assumes synchronous active-low reset.
module sdr_cmd_classifier_chk
    import sdr_cmd_pkg::*;
#(
    parameter int BANKS = 2
)(
    input logic                     clk,
    input logic                     rst_n,
    input logic [CMD_N-1:0]         cmd_onehot,
    input logic [$clog2(BANKS)-1:0] cmd_bank,
    input logic [BANKS-1:0]         bank_open,
    input logic                     power_down,
    input logic                     self_refresh,
    input logic                     rd_beat,
    input logic                     rd_oe,
    input logic                     wr_beat,
    input logic                     wr_mask,
    input logic                     viol,
    input logic                     proto_err
);

    // R1
    onehot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_onehot) == 1);

    // R6
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[CMD_ACT] |-> bank_open[cmd_bank]);

    // R5
    pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[CMD_PRE_ALL] |-> (bank_open == '0));

    // R6
    autopre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_onehot[CMD_RDA] || cmd_onehot[CMD_WRA]) |-> !bank_open[cmd_bank]);

    // R7
    suspend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[CMD_SUSP] |-> $stable(bank_open));

    // R8
    mask_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |-> wr_beat);

    // R9
    oe_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> rd_beat);

    // R11
    modes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(power_down && self_refresh));

    // R11
    pd_entry_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_down) |-> (cmd_onehot[CMD_NOP] || cmd_onehot[CMD_DESEL]));

    // R12
    viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> !viol);

    // R13
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

bind sdr_cmd_classifier sdr_cmd_classifier_chk #(.BANKS(BANKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_onehot   (cmd_onehot),
    .cmd_bank     (cmd_bank),
    .bank_open    (bank_open),
    .power_down   (power_down),
    .self_refresh (self_refresh),
    .rd_beat      (rd_beat),
    .rd_oe        (rd_oe),
    .wr_beat      (wr_beat),
    .wr_mask      (wr_mask),
    .viol         (viol),
    .proto_err    (proto_err)
);

// File: tb/sdr_cmd_classifier_test.sv
// Directed bench for the SDRAM command decoder: one task per scenario.
module sdr_cmd_classifier_test;

    localparam int CL  = 2;
    localparam int BL  = 4;
    localparam int LIM = 16;

    // Command bit positions, taken from the requirements.
    localparam int I_SUSP = 0, I_DESEL = 1, I_NOP = 2, I_MRS = 3, I_AREF = 4,
                   I_SREF = 5, I_PRE1 = 6, I_PREA = 7, I_ACT = 8, I_WR = 9,
                   I_WRA = 10, I_RD = 11, I_RDA = 12, I_BST = 13;

    localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_PRE = 3'b010,
                           P_ACT = 3'b011, P_WR = 3'b100, P_RD = 3'b101,
                           P_BST = 3'b110, P_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        dqm = 1'b0, bank_sel = 1'b0, ap_bit = 1'b0;
    logic [10:0] addr_lo = '0;
    logic [13:0] cmd_onehot;
    logic        cmd_bank, cmd_ap;
    logic [10:0] cmd_addr;
    logic [1:0]  bank_open;
    logic        power_down, self_refresh, rd_beat, rd_oe, wr_beat, wr_mask, viol, proto_err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdr_cmd_classifier #(
        .BANKS(2), .ADDR_W(11), .CAS_LAT(CL), .BURST_LEN(BL), .REF_LIMIT(LIM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .bank_sel(bank_sel),
        .ap_bit(ap_bit), .addr_lo(addr_lo), .cmd_onehot(cmd_onehot),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_addr(cmd_addr),
        .bank_open(bank_open), .power_down(power_down), .self_refresh(self_refresh),
        .rd_beat(rd_beat), .rd_oe(rd_oe), .wr_beat(wr_beat), .wr_mask(wr_mask),
        .viol(viol), .proto_err(proto_err)
    );

    function automatic logic [13:0] oh(input int i);
        return 14'(1) << i;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive pins at the falling edge, return just after the next rising edge.
    task automatic cyc(input logic k, input logic c, input logic [2:0] p,
                       input logic b, input logic a, input logic d, input logic [10:0] ad);
        @(negedge clk);
        cke = k; cs_n = c; {ras_n, cas_n, we_n} = p;
        bank_sel = b; ap_bit = a; dqm = d; addr_lo = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic nop(input logic d = 1'b0);
        cyc(1'b1, 1'b0, P_NOP, 1'b0, 1'b0, d, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) nop();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset cmd", cmd_onehot, oh(I_NOP));
        chk("R1 reset banks", bank_open, 2'b00);
        chk("R1 reset flags", {power_down, self_refresh, viol, proto_err, rd_beat, rd_oe, wr_beat, wr_mask}, 8'h00);
    endtask

    task automatic t_decode();
        do_reset();
        cyc(1, 1, P_ACT, 0, 0, 0, 11'h011);
        chk("R2 deselect over activate", cmd_onehot, oh(I_DESEL));
        chk("R2 no bank change", bank_open, 2'b00);
        cyc(1, 0, P_PRE, 1, 0, 0, 0);
        chk("R3 precharge", cmd_onehot, oh(I_PRE1));
        cyc(1, 0, P_ACT, 1, 0, 0, 11'h155);
        chk("R3 activate", cmd_onehot, oh(I_ACT));
        chk("R6 fields", {cmd_bank, cmd_ap, cmd_addr}, {1'b1, 1'b0, 11'h155});
        cyc(1, 0, P_WR, 1, 0, 0, 11'h02a);
        chk("R3 write", cmd_onehot, oh(I_WR));
        cyc(1, 0, P_RD, 1, 0, 0, 11'h02b);
        chk("R3 read", cmd_onehot, oh(I_RD));
        cyc(1, 0, P_BST, 0, 0, 0, 0);
        chk("R3 terminate", cmd_onehot, oh(I_BST));
        nop();
        chk("R3 nop", cmd_onehot, oh(I_NOP));
        cyc(1, 0, P_MRS, 0, 0, 0, 11'h033);
        chk("R3 mode set", {cmd_onehot, cmd_addr}, {oh(I_MRS), 11'h033});
        cyc(1, 0, P_REF, 0, 0, 0, 0);
        chk("R4 auto refresh", cmd_onehot, oh(I_AREF));
        cyc(1, 1, P_MRS, 0, 0, 0, 0);
        chk("R2 deselect over mode set", cmd_onehot, oh(I_DESEL));
        chk("R13 legal sequence no error", proto_err, 1'b0);
    endtask

    task automatic t_banks();
        do_reset();
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        chk("R5 open A", bank_open, 2'b01);
        cyc(1, 0, P_ACT, 1, 0, 0, 0);
        chk("R5 open B", bank_open, 2'b11);
        cyc(1, 0, P_PRE, 0, 0, 0, 0);
        chk("R5 single precharge A", bank_open, 2'b10);
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        cyc(1, 0, P_PRE, 0, 1, 0, 0);
        chk("R5 precharge all", {cmd_onehot, bank_open}, {oh(I_PREA), 2'b00});
        cyc(1, 0, P_ACT, 1, 0, 0, 0);
        cyc(1, 0, P_WR, 1, 1, 0, 0);
        chk("R6 write auto-precharge", {cmd_onehot, cmd_ap, bank_open}, {oh(I_WRA), 1'b1, 2'b00});
        repeat (4) nop();
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        cyc(1, 0, P_RD, 0, 1, 0, 0);
        chk("R6 read auto-precharge", {cmd_onehot, bank_open}, {oh(I_RDA), 2'b00});
        chk("R13 no error yet", proto_err, 1'b0);
    endtask

    task automatic t_proto();
        do_reset();
        cyc(1, 0, P_RD, 0, 0, 0, 0);
        chk("R13 read closed bank", proto_err, 1'b1);
        repeat (3) nop();
        chk("R13 sticky", proto_err, 1'b1);
        do_reset();
        chk("R13 cleared by reset", proto_err, 1'b0);
        cyc(1, 0, P_ACT, 1, 0, 0, 0);
        chk("R13 first activate ok", proto_err, 1'b0);
        cyc(1, 0, P_ACT, 1, 0, 0, 0);
        chk("R13 double activate", proto_err, 1'b1);
    endtask

    task automatic t_refresh();
        do_reset();
        cyc(1, 0, P_REF, 0, 0, 0, 0);
        chk("R4 auto refresh", {cmd_onehot, self_refresh}, {oh(I_AREF), 1'b0});
        cyc(0, 0, P_REF, 0, 0, 0, 0);
        chk("R4 self-refresh entry", {cmd_onehot, self_refresh}, {oh(I_SREF), 1'b1});
        cyc(0, 0, P_ACT, 0, 0, 0, 0);
        chk("R7 suspended ignores activate", {cmd_onehot, bank_open}, {oh(I_SUSP), 2'b00});
        chk("R4 self-refresh held", self_refresh, 1'b1);
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        chk("R4 exit edge", {cmd_onehot, self_refresh, bank_open}, {oh(I_SUSP), 1'b0, 2'b00});
        nop();
        chk("R7 commands resume", cmd_onehot, oh(I_NOP));
    endtask

    task automatic t_powerdown();
        int pulses = 0;
        int at = -1;
        do_reset();
        cyc(0, 0, P_NOP, 0, 0, 0, 0);
        chk("R11 entry banks closed", {cmd_onehot, power_down, viol}, {oh(I_NOP), 1'b1, 1'b0});
        cyc(0, 0, P_NOP, 0, 0, 0, 0);
        chk("R11 held", {cmd_onehot, power_down}, {oh(I_SUSP), 1'b1});
        cyc(1, 0, P_NOP, 0, 0, 0, 0);
        chk("R11 exit", power_down, 1'b0);
        nop();
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        cyc(0, 1, P_NOP, 0, 0, 0, 0);
        chk("R11 entry with open bank", {cmd_onehot, power_down, viol}, {oh(I_DESEL), 1'b1, 1'b1});
        for (int i = 1; i <= LIM + 3; i++) begin
            cyc(0, 0, P_NOP, 0, 0, 0, 0);
            if (viol) begin
                pulses++;
                at = i;
            end
        end
        chk("R12 one expiry pulse", pulses, 1);
        chk("R12 expiry cycle", at, LIM);
        chk("R11 bank kept open", bank_open, 2'b01);
        cyc(1, 0, P_NOP, 0, 0, 0, 0);
        chk("R11 exit after expiry", power_down, 1'b0);
    endtask

    task automatic t_write();
        logic eb [5] = '{1, 1, 1, 1, 0};
        logic em [5] = '{0, 1, 0, 0, 0};
        logic dq [5] = '{0, 1, 0, 0, 0};
        do_reset();
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        cyc(1, 0, P_WR, 0, 0, dq[0], 0);
        chk("R8 beat 0", {wr_beat, wr_mask}, {eb[0], em[0]});
        for (int i = 1; i < 5; i++) begin
            nop(dq[i]);
            chk("R8 write window", {wr_beat, wr_mask, rd_beat}, {eb[i], em[i], 1'b0});
        end
    endtask

    task automatic t_write_bst();
        do_reset();
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        cyc(1, 0, P_WR, 0, 0, 0, 0);
        nop();
        chk("R10 write running", wr_beat, 1'b1);
        cyc(1, 0, P_BST, 0, 0, 0, 0);
        chk("R10 write stops at terminate", wr_beat, 1'b0);
        nop();
        chk("R10 write stays stopped", wr_beat, 1'b0);
    endtask

    task automatic t_read();
        logic eb [7] = '{0, 0, 1, 1, 1, 1, 0};
        logic eo [7] = '{0, 0, 1, 1, 1, 0, 0};
        logic dq [7] = '{0, 0, 0, 1, 0, 0, 0};
        do_reset();
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        cyc(1, 0, P_RD, 0, 0, dq[0], 0);
        chk("R9 no beat at command", rd_beat, eb[0]);
        for (int i = 1; i < 7; i++) begin
            nop(dq[i]);
            chk("R9 read window", {rd_beat, rd_oe, wr_beat}, {eb[i], eo[i], 1'b0});
        end
    endtask

    task automatic t_read_bst();
        do_reset();
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        cyc(1, 0, P_RD, 0, 0, 0, 0);
        cyc(1, 0, P_BST, 0, 0, 0, 0);
        nop();
        chk("R10 read beat before latency", rd_beat, 1'b1);
        nop();
        chk("R10 read stops after latency", rd_beat, 1'b0);
        nop();
        chk("R10 read stays stopped", rd_beat, 1'b0);
    endtask

    task automatic t_suspend();
        int beats = 0;
        logic saw_pd = 1'b0;
        do_reset();
        cyc(1, 0, P_ACT, 0, 0, 0, 0);
        cyc(1, 0, P_WR, 0, 0, 0, 0);
        beats += int'(wr_beat);
        cyc(0, 0, P_NOP, 0, 0, 0, 0);
        beats += int'(wr_beat);
        saw_pd |= power_down;
        cyc(0, 0, P_NOP, 0, 0, 0, 0);
        chk("R7 suspended edge", cmd_onehot, oh(I_SUSP));
        beats += int'(wr_beat);
        saw_pd |= power_down;
        cyc(1, 0, P_NOP, 0, 0, 0, 0);
        beats += int'(wr_beat);
        saw_pd |= power_down;
        for (int i = 0; i < 4; i++) begin
            nop();
            beats += int'(wr_beat);
        end
        chk("R7 burst stretched by suspend", beats, BL + 2);
        chk("R11 no power-down during burst", saw_pd, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_banks();
        t_proto();
        t_refresh();
        t_powerdown();
        t_write();
        t_write_bst();
        t_read();
        t_read_bst();
        t_suspend();
        summary();
        $finish;
    end

endmodule